// File: doc/BRIEF.md
# Colour Lookup Table with Packed Entries and Write-Time Conversion

The block stores the colour palette of a display controller. Software sees 128 32-bit words in the register window at byte offsets 0x200 through 0x3FF. Each word carries two 16-bit colour entries, and a read returns the word exactly as it was written. The pixel pipeline does not decode these raw entries. Every bus write also feeds a second, 256-entry table that already holds each colour in the pixel format the display runs at. The pixel pipeline presents an 8-bit colour index and gets the converted pixel back one clock later.

The pixel format comes from a 3-bit depth input. The block samples it at the time of each write. The converted table is split into an even bank and an odd bank. The low entry of a word lands in the even bank one cycle after the write, and the high entry lands in the odd bank one cycle after that. Back-to-back writes on every cycle are therefore accepted without stalling. A change of the depth input does not rebuild the entries already stored. Only entries written later use the new format.

Top module: `clut_ram`

## Requirements
- R1: A bus access falls in the window when byte-offset bits [11:9] equal 3'b001 (0x200 to 0x3FF). The word index is offset bits [8:2], and offset bits [1:0] are ignored. A write outside the window changes no stored word and no converted entry.
- R2: A read strobe inside the window puts the stored 32-bit word on the read data output in the next cycle. A cycle with no read strobe, or a read outside the window, leaves the read data at zero in the next cycle.
- R3: Word n carries colour entry 2n in bits [15:0] and entry 2n+1 in bits [31:16].
- R4: Within a 16-bit entry, red occupies bits [4:0], green [9:5] and blue [14:10]. Bit 15 has no effect on the converted pixel.
- R5: Each 5-bit component c is first widened to the 8-bit value c<<3. Depth code 0 then gives {r[7:5],g[7:5],b[7:6]} and code 1 gives {r[7:3],g[7:3],b[7:3]}. Code 2 gives {r[7:3],g[7:2],b[7:3]}. Codes 3 to 7 give {r,g,b}, with red in bits [23:16]. Narrower results are zero-extended to 24 bits.
- R6: An index applied to the lookup input is sampled at a clock edge, and its converted pixel appears on the lookup output after that edge.
- R7: For a write sampled at edge T, a lookup of entry 2n sampled at edge T+1 still returns the old pixel, and one sampled at T+2 returns the new pixel. For entry 2n+1, lookups sampled at T+1 and T+2 return the old pixel and one sampled at T+3 returns the new pixel.
- R8: The depth code is captured at the write edge. Changing it afterwards neither alters the pending conversion nor rebuilds entries already stored.
- R9: Writes on consecutive cycles are all accepted, and every one of their entries reaches the converted table.
- R10: While reset is asserted, the read data and the lookup output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, two packed entries |
| bus_rdata | output | 32 | Registered read data |
| depth_sel | input | 3 | Output pixel format code |
| lut_idx | input | 8 | Colour index from the pixel pipeline |
| lut_data | output | 24 | Converted pixel, one cycle after the index |

## Verification
A corrupted capture register or a wrong bank select shows up at the lookup port within three cycles of the write. The symptom is the right colour on the neighbouring index, a pixel in the wrong format, or an entry that never changes. The sharpest probe is to step the lookup along a freshly written pair on the exact edges T+1 through T+3. An early or late update of either bank breaks the old/new boundary there. A bad window decode shows up as an alias, where a stray write at 0x1FC or 0x400 overwrites word 127 or word 0. That alias can be read back the very next cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int DATA_W  = 32;
    localparam int ENTRY_W = DATA_W / 2;
    localparam int COMP_W  = 5;
    localparam int PIX_W   = 24;

    typedef enum logic [1:0] {
        FMT_RGB8  = 2'd0,
        FMT_RGB15 = 2'd1,
        FMT_RGB16 = 2'd2,
        FMT_RGB24 = 2'd3
    } pix_fmt_e;

    // colour fields of one packed entry, intensity bit excluded
    typedef struct packed {
        logic [COMP_W-1:0] blue;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] red;
    } colour_t;

    function automatic pix_fmt_e decode_depth(input logic [2:0] code);
        case (code)
            3'd0:    return FMT_RGB8;
            3'd1:    return FMT_RGB15;
            3'd2:    return FMT_RGB16;
            default: return FMT_RGB24;
        endcase
    endfunction

endpackage

// File: rtl/clut_conv.sv
module clut_conv
    import clut_pkg::*;
(
    input  pix_fmt_e         fmt,
    input  colour_t          col,
    output logic [PIX_W-1:0] pix
);

    logic [7:0] r8;
    logic [7:0] g8;
    logic [7:0] b8;

    always_comb begin
        r8 = {col.red,   3'b000};
        g8 = {col.green, 3'b000};
        b8 = {col.blue,  3'b000};
        case (fmt)
            FMT_RGB8:  pix = {16'd0, r8[7:5], g8[7:5], b8[7:6]};
            FMT_RGB15: pix = {9'd0,  r8[7:3], g8[7:3], b8[7:3]};
            FMT_RGB16: pix = {8'd0,  r8[7:3], g8[7:2], b8[7:3]};
            default:   pix = {r8, g8, b8};
        endcase
    end

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read-before-write: a same-edge write is seen one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/clut_ram.sv
module clut_ram
    import clut_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                WORD_CNT = 128,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [2:0]                 depth_sel,
    input  logic [$clog2(WORD_CNT):0]  lut_idx,
    output logic [PIX_W-1:0]           lut_data
);

    localparam int IDX_W = $clog2(WORD_CNT);
    localparam int HALVES = 2;

    typedef struct packed {
        logic             a_vld;
        logic [IDX_W-1:0] a_idx;
        logic [PIX_W-1:0] a_lo;
        logic [PIX_W-1:0] a_hi;
        logic             b_vld;
        logic [IDX_W-1:0] b_idx;
        logic [PIX_W-1:0] b_hi;
        logic             rd_hit;
        logic             lut_odd;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             win_hit;
    logic             wr_hit;
    logic [IDX_W-1:0] widx;
    pix_fmt_e         fmt;
    logic [PIX_W-1:0] conv_pix [HALVES];
    logic [PIX_W-1:0] bank_rd  [HALVES];
    logic [DATA_W-1:0] raw_rd;
    logic [1:0]       addr_lsb_unused;

    assign addr_lsb_unused = bus_addr[1:0];
    assign win_hit = (bus_addr[ADDR_W-1:IDX_W+2] == WIN_BASE[ADDR_W-1:IDX_W+2]);
    assign wr_hit  = bus_wr && win_hit;
    assign widx    = bus_addr[IDX_W+1:2];
    assign fmt     = decode_depth(depth_sel);

    // one converter per packed half
    for (genvar h = 0; h < HALVES; h++) begin : g_conv
        clut_conv u_conv (
            .fmt (fmt),
            .col (colour_t'(bus_wdata[h*ENTRY_W +: ENTRY_W-1])),
            .pix (conv_pix[h])
        );
    end

    // raw word store
    clut_bank #(.DEPTH(WORD_CNT), .WIDTH(DATA_W)) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_hit),
        .waddr (widx),
        .wdata (bus_wdata),
        .raddr (widx),
        .rdata (raw_rd)
    );

    // converted table split by index parity
    for (genvar k = 0; k < HALVES; k++) begin : g_bank
        logic             we_k;
        logic [IDX_W-1:0] wa_k;
        logic [PIX_W-1:0] wd_k;
        if (k == 0) begin : g_even
            assign we_k = st_q.a_vld;
            assign wa_k = st_q.a_idx;
            assign wd_k = st_q.a_lo;
        end else begin : g_odd
            assign we_k = st_q.b_vld;
            assign wa_k = st_q.b_idx;
            assign wd_k = st_q.b_hi;
        end
        clut_bank #(.DEPTH(WORD_CNT), .WIDTH(PIX_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_k),
            .waddr (wa_k),
            .wdata (wd_k),
            .raddr (lut_idx[IDX_W:1]),
            .rdata (bank_rd[k])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.a_vld   = wr_hit;
        st_d.a_idx   = widx;
        st_d.a_lo    = conv_pix[0];
        st_d.a_hi    = conv_pix[1];
        st_d.b_vld   = st_q.a_vld;
        st_d.b_idx   = st_q.a_idx;
        st_d.b_hi    = st_q.a_hi;
        st_d.rd_hit  = bus_rd && win_hit;
        st_d.lut_odd = lut_idx[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = st_q.rd_hit ? raw_rd : '0;
        lut_data  = st_q.lut_odd ? bank_rd[1] : bank_rd[0];
    end

endmodule

// File: rtl/clut_ram_chk.sv
module clut_ram_chk #(
    parameter int                ADDR_W   = 12,
    parameter int                IDX_W    = 7,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [IDX_W:0]    lut_idx,
    input logic [23:0]       lut_data,
    input logic              a_vld,
    input logic [IDX_W-1:0]  a_idx,
    input logic              b_vld,
    input logic [IDX_W-1:0]  b_idx
);

    logic       hit;
    logic [1:0] chk_lsb_unused;

    assign hit = (bus_addr[ADDR_W-1:IDX_W+2] == WIN_BASE[ADDR_W-1:IDX_W+2]);
    assign chk_lsb_unused = bus_addr[1:0];

    p_stray_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> !a_vld);

    p_write_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit) |=> (a_vld && a_idx == $past(bus_addr[IDX_W+1:2])));

    p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit) |=> (bus_rdata == 32'd0));

    p_odd_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld |=> (b_vld && b_idx == $past(a_idx)));

    p_lookup_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a_vld) && !$past(b_vld) && lut_idx == $past(lut_idx))
        |=> $stable(lut_data));

endmodule

bind clut_ram clut_ram_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .lut_idx   (lut_idx),
    .lut_data  (lut_data),
    .a_vld     (st_q.a_vld),
    .a_idx     (st_q.a_idx),
    .b_vld     (st_q.b_vld),
    .b_idx     (st_q.b_idx)
);

// File: tb/clut_ram_test.sv
module clut_ram_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  depth_sel;
    logic [7:0]  lut_idx;
    logic [23:0] lut_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clut_ram uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .depth_sel (depth_sel),
        .lut_idx   (lut_idx),
        .lut_data  (lut_data)
    );

    typedef struct packed {
        logic [2:0]  dep;
        logic [11:0] addr;
        logic [31:0] word;
        logic [23:0] lo_exp;
        logic [23:0] hi_exp;
    } vec_t;

    // format, offset, packed word, expected pixels for entry 2n and 2n+1
    localparam vec_t VECS [6] = '{
        '{3'd0, 12'h200, 32'hFC00001F, 24'h0000E0, 24'h000003},
        '{3'd1, 12'h204, 32'h7FFF0C41, 24'h000443, 24'h007FFF},
        '{3'd2, 12'h3FC, 32'h00200630, 24'h008441, 24'h000040},
        '{3'd3, 12'h2A3, 32'hFFFF0C41, 24'h081018, 24'hF8F8F8},
        '{3'd4, 12'h300, 32'h03E0001F, 24'hF80000, 24'h00F800},
        '{3'd7, 12'h208, 32'h00007C00, 24'h0000F8, 24'h000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd   = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic lookup(input string req, input logic [7:0] idx, input logic [23:0] exp);
        lut_idx = idx;
        @(negedge clk);
        check(req, {8'd0, lut_data}, {8'd0, exp});
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        depth_sel = '0;
        lut_idx   = '0;
        idle(3);
        check("R10 rdata in reset", bus_rdata, 32'd0);
        check("R10 lut_data in reset", {8'd0, lut_data}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // table walk: R3 R4 R5 plus raw readback R2
        for (int i = 0; i < 6; i++) begin
            depth_sel = VECS[i].dep;
            bus_write(VECS[i].addr, VECS[i].word);
            idle(3);
            bus_read("R2 raw readback", VECS[i].addr, VECS[i].word);
            lookup("R3 R4 R5 low entry", {VECS[i].addr[8:2], 1'b0}, VECS[i].lo_exp);
            lookup("R3 R4 R5 high entry", {VECS[i].addr[8:2], 1'b1}, VECS[i].hi_exp);
        end

        // R2: no strobe and out-of-window read leave zero
        idle(1);
        check("R2 no read strobe", bus_rdata, 32'd0);
        bus_read("R2 read outside window", 12'h100, 32'd0);

        // R1: stray writes must not alias into word 0 or word 127
        depth_sel = 3'd3;
        bus_write(12'h400, 32'h12345678);
        bus_write(12'h1FC, 32'h9ABCDEF0);
        idle(3);
        bus_read("R1 word 0 untouched", 12'h200, 32'hFC00001F);
        bus_read("R1 word 127 untouched", 12'h3FC, 32'h00200630);
        bus_read("R1 low offset bits ignored", 12'h3FF, 32'h00200630);
        lookup("R1 entry 0 untouched", 8'd0, 24'h0000E0);
        lookup("R1 entry 255 untouched", 8'd255, 24'h000040);

        // R7 and R6: even entry update edge
        bus_write(12'h228, 32'h00000000);
        idle(3);
        bus_write(12'h228, 32'hFFFFFFFF);
        lut_idx = 8'd20;
        @(negedge clk);
        check("R7 entry 2n old at T+1", {8'd0, lut_data}, 32'h000000);
        @(negedge clk);
        check("R7 entry 2n new at T+2", {8'd0, lut_data}, 32'hF8F8F8);

        // R7: odd entry update edge
        bus_write(12'h228, 32'h00000000);
        idle(3);
        bus_write(12'h228, 32'hFFFFFFFF);
        lut_idx = 8'd21;
        @(negedge clk);
        check("R7 entry 2n+1 old at T+1", {8'd0, lut_data}, 32'h000000);
        @(negedge clk);
        check("R7 entry 2n+1 old at T+2", {8'd0, lut_data}, 32'h000000);
        @(negedge clk);
        check("R7 entry 2n+1 new at T+3", {8'd0, lut_data}, 32'hF8F8F8);

        // R8: depth change right after a write, then no rebuild
        depth_sel = 3'd0;
        bus_write(12'h22C, 32'h001F001F);
        depth_sel = 3'd4;
        idle(3);
        lookup("R8 low uses write-time format", 8'd22, 24'h0000E0);
        lookup("R8 high uses write-time format", 8'd23, 24'h0000E0);
        bus_write(12'h230, 32'h001F001F);
        idle(3);
        lookup("R8 later write uses new format", 8'd24, 24'hF80000);
        lookup("R8 old entry not rebuilt", 8'd22, 24'h0000E0);

        // R9: writes on three consecutive cycles
        depth_sel = 3'd1;
        bus_wr    = 1'b1;
        bus_addr  = 12'h250;
        bus_wdata = 32'h0C417FFF;
        @(negedge clk);
        bus_addr  = 12'h254;
        bus_wdata = 32'h7FFF0C41;
        @(negedge clk);
        bus_addr  = 12'h258;
        bus_wdata = 32'h00200630;
        @(negedge clk);
        bus_wr    = 1'b0;
        idle(3);
        lookup("R9 burst entry 40", 8'd40, 24'h007FFF);
        lookup("R9 burst entry 41", 8'd41, 24'h000443);
        lookup("R9 burst entry 42", 8'd42, 24'h000443);
        lookup("R9 burst entry 43", 8'd43, 24'h007FFF);
        lookup("R9 burst entry 44", 8'd44, 24'h004221);
        lookup("R9 burst entry 45", 8'd45, 24'h000020);
        bus_read("R9 burst raw word", 12'h254, 32'h7FFF0C41);

        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule